// File: doc/BRIEF.md
# LCD Controller Register Block

This block is the register front end of a colour LCD controller. It sits on a simple 32-bit peripheral bus that addresses a 4 KB window, one access per cycle. The block holds the panel timing words, the upper and lower frame base addresses, a control word, and an interrupt mask and raw status. It turns these into the signals the display pipeline uses: a display enable, a pixel-depth code, three colour and byte-order flags, the active column and row counts, and the frame base address.

Software sets the geometry by writing two of the timing words. The block works out the active columns and rows from those writes and registers them. A board-variant strap swaps the offsets of the mask and control words. The top 32 bytes of the window return a fixed eight-byte identification sequence. The raw status bits are set by a per-bit input that stands in for the interrupt sources. A single interrupt line shows whether any unmasked status bit is set.

Each access is sorted into one of four response states: `ST_IDLE` (no access), `ST_RDATA` (a mapped read), `ST_WACK` (a mapped write) and `ST_FAULT` (an access that hits nothing). The next state depends only on the access presented in the current cycle. The transitions are: idle-to-read, idle-to-write and idle-to-fault; the same three from any other state when accesses come back to back; and return-to-idle from any state when select is low. Read data and the error pulse come from this state, so they appear in the cycle after the access.

Top module: `lcdreg_top`

## Requirements
- R1: After reset every output is zero: read data, error, interrupt, enable, depth code, flags, columns, rows and base.
- R2: The word index is byte-offset bits [11:2], and bits [1:0] must be zero. Indices 0 to 3 (timing words 0 to 3), 4 (upper base) and 5 (lower base) are read/write and read back in full. Read data is valid only in the cycle after a read access and is zero in every other cycle.
- R3: When the strap is low, index 6 is the interrupt mask and index 7 is the control word. When the strap is high, the two swap for both reads and writes.
- R4: In the cycle after a write of value v to timing word 0, columns equals ((v AND 0xFC) + 4) * 4.
- R5: In the cycle after a write of value v to timing word 1, rows equals (v AND 0x3FF) + 1.
- R6: Control bits set the outputs in the cycle after a control write. Enable is high only when bit 0 and bit 11 are both set. The depth code is bits [3:1]. Bit 8 is the BGR flag, bit 9 is the byte-order flag and bit 10 is the pixel-order flag.
- R7: Each raw status bit is set by a high level on its status-set input bit. Index 8 reads the raw status and index 9 reads raw status AND mask. If a bit is set and cleared in the same cycle, the set wins.
- R8: A write to index 10 clears each raw status bit that is 1 in the written value.
- R9: The interrupt output equals the OR of the raw status bits ANDed with the mask. It follows a mask write, a clear or a status set in the next cycle.
- R10: Indices 11 and 12 read back the upper and lower base addresses.
- R11: Byte offsets 0xFE0 to 0xFFC read one identification byte per word, zero-extended, in this order: 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R12: An unmapped access reads zero, changes no state and pulses the error output high for exactly one cycle, the cycle after the access. Unmapped accesses are: a nonzero byte offset in bits [1:0]; indices 13 up to the identification region; a read of index 10; and a write to indices 8, 9, 11 or 12 or to the identification region.
- R13: The base output always equals the upper base address register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| variant_i | input | 1 | Board strap that swaps the mask and control offsets |
| bus_sel_i | input | 1 | Access request this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte offset inside the window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the read |
| bus_err_o | output | 1 | One-cycle pulse after an unmapped access |
| irq_set_i | input | 4 | Per-bit raw status set |
| irq_o | output | 1 | OR of masked status |
| disp_en_o | output | 1 | Display enabled (enable and power bits) |
| bpp_o | output | 3 | Pixel-depth code |
| bgr_o | output | 1 | BGR colour order |
| be_byte_o | output | 1 | Big-endian byte order |
| be_pix_o | output | 1 | Big-endian pixel order within a byte |
| cols_o | output | 11 | Active columns |
| rows_o | output | 11 | Active rows |
| base_o | output | 32 | Upper frame base address |

## Verification
A corrupted stored word shows up in one of two ways. It appears on a decoded output (columns, rows, enable, flags, base, interrupt) in the cycle after the write that caused it. Otherwise it appears on the read data one cycle after the next read of that index. A response state that is entered wrongly shows in the cycle after the access: there is a stray or missing error pulse, or read data is non-zero outside a read response. The reference model tracks every stored word and both outputs of the response state, and it compares all outputs on every clock. A fault is therefore reported in the first cycle where it reaches a port.

// File: rtl/lcdreg_pkg.sv
package lcdreg_pkg;

    localparam int TIM_N = 4;

    // Control word bit positions (decoded by the display pipeline)
    localparam int CTL_EN     = 0;
    localparam int CTL_BPP_LO = 1;
    localparam int CTL_BGR    = 8;
    localparam int CTL_BEBYTE = 9;
    localparam int CTL_BEPIX  = 10;
    localparam int CTL_PWR    = 11;

    typedef enum logic [3:0] {
        RS_TIM0, RS_TIM1, RS_TIM2, RS_TIM3,
        RS_UPBASE, RS_LPBASE, RS_MASK, RS_CTRL,
        RS_RAW, RS_MASKED, RS_CLEAR, RS_UPCUR,
        RS_LPCUR, RS_IDENT, RS_NONE
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_RDATA, ST_WACK, ST_FAULT
    } acc_state_e;

    function automatic logic [7:0] ident_byte(input logic [2:0] k);
        logic [7:0] b;
        unique case (k)
            3'd0: b = 8'h10;
            3'd1: b = 8'h11;
            3'd2: b = 8'h04;
            3'd3: b = 8'h00;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            3'd7: b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/lcdreg_decode.sv
module lcdreg_decode
    import lcdreg_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-3:0] idx_i,
    input  logic              misalign_i,
    input  logic              wr_i,
    input  logic              variant_i,
    output reg_sel_e          sel_o,
    output logic              hit_o
);
    localparam int IDX_W    = ADDR_W - 2;
    localparam int ID_FIRST = (1 << IDX_W) - 8;

    reg_sel_e sel;
    logic     readable;
    logic     writable;

    always_comb begin
        sel = RS_NONE;
        if (idx_i >= IDX_W'(ID_FIRST)) begin
            sel = RS_IDENT;
        end else begin
            case (idx_i)
                IDX_W'(0):  sel = RS_TIM0;
                IDX_W'(1):  sel = RS_TIM1;
                IDX_W'(2):  sel = RS_TIM2;
                IDX_W'(3):  sel = RS_TIM3;
                IDX_W'(4):  sel = RS_UPBASE;
                IDX_W'(5):  sel = RS_LPBASE;
                IDX_W'(6):  sel = variant_i ? RS_CTRL : RS_MASK;
                IDX_W'(7):  sel = variant_i ? RS_MASK : RS_CTRL;
                IDX_W'(8):  sel = RS_RAW;
                IDX_W'(9):  sel = RS_MASKED;
                IDX_W'(10): sel = RS_CLEAR;
                IDX_W'(11): sel = RS_UPCUR;
                IDX_W'(12): sel = RS_LPCUR;
                default:    sel = RS_NONE;
            endcase
        end
    end

    always_comb begin
        readable = (sel != RS_NONE) && (sel != RS_CLEAR);
        writable = (sel == RS_TIM0) || (sel == RS_TIM1) || (sel == RS_TIM2)
                || (sel == RS_TIM3) || (sel == RS_UPBASE) || (sel == RS_LPBASE)
                || (sel == RS_MASK) || (sel == RS_CTRL) || (sel == RS_CLEAR);
    end

    assign sel_o = sel;
    assign hit_o = !misalign_i && (wr_i ? writable : readable);

endmodule

// File: rtl/lcdreg_geom.sv
module lcdreg_geom #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cols_we_i,
    input  logic [5:0]       cols_field_i,
    input  logic             rows_we_i,
    input  logic [9:0]       rows_field_i,
    output logic [CNT_W-1:0] cols_o,
    output logic [CNT_W-1:0] rows_o
);
    localparam int COL_SHIFT = 4;   // ((v & 0xFC) + 4) * 4 == (v[7:2] + 1) * 16

    logic [CNT_W-1:0] col_units;
    logic [CNT_W-1:0] row_count;

    assign col_units = CNT_W'(cols_field_i) + CNT_W'(1);
    assign row_count = CNT_W'(rows_field_i) + CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cols_o <= '0;
            rows_o <= '0;
        end else begin
            if (cols_we_i) cols_o <= col_units << COL_SHIFT;
            if (rows_we_i) rows_o <= row_count;
        end
    end

endmodule

// File: rtl/lcdreg_irq.sv
module lcdreg_irq #(
    parameter int IRQ_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] set_i,
    input  logic             mask_we_i,
    input  logic             clr_we_i,
    input  logic [IRQ_W-1:0] wdata_i,
    output logic [IRQ_W-1:0] raw_o,
    output logic [IRQ_W-1:0] mask_o,
    output logic             irq_o
);
    logic [IRQ_W-1:0] raw_n;
    logic [IRQ_W-1:0] mask_n;

    always_comb begin
        raw_n  = (raw_o & ~(clr_we_i ? wdata_i : '0)) | set_i;
        mask_n = mask_we_i ? wdata_i : mask_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_o  <= '0;
            mask_o <= '0;
            irq_o  <= 1'b0;
        end else begin
            raw_o  <= raw_n;
            mask_o <= mask_n;
            irq_o  <= |(raw_n & mask_n);
        end
    end

endmodule

// File: rtl/lcdreg_top.sv
module lcdreg_top
    import lcdreg_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int IRQ_W  = 4,
    parameter int CNT_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              variant_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              bus_err_o,
    input  logic [IRQ_W-1:0]  irq_set_i,
    output logic              irq_o,
    output logic              disp_en_o,
    output logic [2:0]        bpp_o,
    output logic              bgr_o,
    output logic              be_byte_o,
    output logic              be_pix_o,
    output logic [CNT_W-1:0]  cols_o,
    output logic [CNT_W-1:0]  rows_o,
    output logic [DATA_W-1:0] base_o
);
    localparam int IDX_W = ADDR_W - 2;
    localparam int TSEL_W = $clog2(TIM_N);

    reg_sel_e          sel;
    logic              hit;
    logic              we;
    logic [IDX_W-1:0]  idx;
    logic [TSEL_W-1:0] tsel;
    logic              tim_hit;

    acc_state_e        state_q, state_n;
    logic [DATA_W-1:0] rd_val;
    logic [DATA_W-1:0] rdata_q;

    logic [DATA_W-1:0] tim_q [TIM_N];
    logic [DATA_W-1:0] upbase_q;
    logic [DATA_W-1:0] lpbase_q;
    logic [DATA_W-1:0] ctrl_q;
    logic [IRQ_W-1:0]  raw;
    logic [IRQ_W-1:0]  mask;

    assign idx  = bus_addr_i[ADDR_W-1:2];
    assign tsel = bus_addr_i[TSEL_W+1:2];

    lcdreg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .idx_i      (idx),
        .misalign_i (|bus_addr_i[1:0]),
        .wr_i       (bus_wr_i),
        .variant_i  (variant_i),
        .sel_o      (sel),
        .hit_o      (hit)
    );

    assign we      = bus_sel_i && bus_wr_i && hit;
    assign tim_hit = (sel == RS_TIM0) || (sel == RS_TIM1)
                  || (sel == RS_TIM2) || (sel == RS_TIM3);

    // Stored words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < TIM_N; t++) tim_q[t] <= '0;
            upbase_q <= '0;
            lpbase_q <= '0;
            ctrl_q   <= '0;
        end else if (we) begin
            for (int t = 0; t < TIM_N; t++) begin
                if (tim_hit && (tsel == TSEL_W'(t))) tim_q[t] <= bus_wdata_i;
            end
            if (sel == RS_UPBASE) upbase_q <= bus_wdata_i;
            if (sel == RS_LPBASE) lpbase_q <= bus_wdata_i;
            if (sel == RS_CTRL)   ctrl_q   <= bus_wdata_i;
        end
    end

    lcdreg_geom #(.CNT_W(CNT_W)) u_geom (
        .clk          (clk),
        .rst_n        (rst_n),
        .cols_we_i    (we && (sel == RS_TIM0)),
        .cols_field_i (bus_wdata_i[7:2]),
        .rows_we_i    (we && (sel == RS_TIM1)),
        .rows_field_i (bus_wdata_i[9:0]),
        .cols_o       (cols_o),
        .rows_o       (rows_o)
    );

    lcdreg_irq #(.IRQ_W(IRQ_W)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (irq_set_i),
        .mask_we_i (we && (sel == RS_MASK)),
        .clr_we_i  (we && (sel == RS_CLEAR)),
        .wdata_i   (bus_wdata_i[IRQ_W-1:0]),
        .raw_o     (raw),
        .mask_o    (mask),
        .irq_o     (irq_o)
    );

    // Read multiplexer
    always_comb begin
        rd_val = '0;
        unique case (sel)
            RS_TIM0, RS_TIM1,
            RS_TIM2, RS_TIM3:   rd_val = tim_q[tsel];
            RS_UPBASE, RS_UPCUR: rd_val = upbase_q;
            RS_LPBASE, RS_LPCUR: rd_val = lpbase_q;
            RS_MASK:            rd_val = DATA_W'(mask);
            RS_CTRL:            rd_val = ctrl_q;
            RS_RAW:             rd_val = DATA_W'(raw);
            RS_MASKED:          rd_val = DATA_W'(raw & mask);
            RS_IDENT:           rd_val = DATA_W'(ident_byte(idx[2:0]));
            default:            rd_val = '0;
        endcase
    end

    // Response state: next state from the access presented this cycle
    always_comb begin
        state_n = ST_IDLE;
        unique case ({bus_sel_i, hit, bus_wr_i})
            3'b111:  state_n = ST_WACK;
            3'b110:  state_n = ST_RDATA;
            3'b100,
            3'b101:  state_n = ST_FAULT;
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            unique case (state_n)
                ST_RDATA: rdata_q <= rd_val;
                ST_IDLE,
                ST_WACK,
                ST_FAULT: rdata_q <= '0;
                default:  rdata_q <= '0;
            endcase
        end
    end

    assign bus_rdata_o = rdata_q;
    assign bus_err_o   = (state_q == ST_FAULT);

    assign disp_en_o = ctrl_q[CTL_EN] && ctrl_q[CTL_PWR];
    assign bpp_o     = ctrl_q[CTL_BPP_LO+2:CTL_BPP_LO];
    assign bgr_o     = ctrl_q[CTL_BGR];
    assign be_byte_o = ctrl_q[CTL_BEBYTE];
    assign be_pix_o  = ctrl_q[CTL_BEPIX];
    assign base_o    = upbase_q;

endmodule

// File: rtl/lcdreg_chk.sv
module lcdreg_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int IRQ_W  = 4,
    parameter int CNT_W  = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel_i,
    input logic              bus_wr_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [IRQ_W-1:0]  wdata_lo,
    input logic [IRQ_W-1:0]  irq_set_i,
    input logic [DATA_W-1:0] bus_rdata_o,
    input logic              bus_err_o,
    input logic              irq_o,
    input logic              disp_en_o,
    input logic [CNT_W-1:0]  cols_o,
    input logic [CNT_W-1:0]  rows_o
);
    localparam int IDX_W    = ADDR_W - 2;
    localparam int ID_FIRST = (1 << IDX_W) - 8;

    a_r2_rdata_only_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sel_i || bus_wr_i) |=> (bus_rdata_o == '0));

    a_r12_err_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err_o |-> $past(bus_sel_i));

    a_r12_err_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err_o |-> (bus_rdata_o == '0));

    a_r6_en_moves_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(disp_en_o) |-> $past(bus_sel_i && bus_wr_i));

    a_r4_cols_moves_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cols_o) |-> $past(bus_sel_i && bus_wr_i));

    a_r4_cols_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (cols_o != '0) |-> ((cols_o[3:0] == 4'd0) && (cols_o <= CNT_W'(1024))));

    a_r5_rows_range: assert property (@(posedge clk) disable iff (!rst_n)
        rows_o <= CNT_W'(1024));

    a_r8_full_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && bus_wr_i && (bus_addr_i[ADDR_W-1:2] == IDX_W'(10))
         && (bus_addr_i[1:0] == 2'b00) && (&wdata_lo) && (irq_set_i == '0))
        |=> !irq_o);

    a_r11_first_ident: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && !bus_wr_i && (bus_addr_i[ADDR_W-1:2] == IDX_W'(ID_FIRST))
         && (bus_addr_i[1:0] == 2'b00))
        |=> (bus_rdata_o == DATA_W'(8'h10)));

endmodule

bind lcdreg_top lcdreg_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IRQ_W(IRQ_W), .CNT_W(CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .wdata_lo    (bus_wdata_i[IRQ_W-1:0]),
    .irq_set_i   (irq_set_i),
    .bus_rdata_o (bus_rdata_o),
    .bus_err_o   (bus_err_o),
    .irq_o       (irq_o),
    .disp_en_o   (disp_en_o),
    .cols_o      (cols_o),
    .rows_o      (rows_o)
);

// File: tb/tb_lcdreg_top.sv
module tb_lcdreg_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        variant = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  iset = '0;
    logic [31:0] rdata;
    logic        err, irq, en, bgr, beb, bep;
    logic [2:0]  bpp;
    logic [10:0] cols, rows;
    logic [31:0] base;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    lcdreg_top dut (
        .clk(clk), .rst_n(rst_n), .variant_i(variant),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .bus_err_o(err), .irq_set_i(iset), .irq_o(irq),
        .disp_en_o(en), .bpp_o(bpp), .bgr_o(bgr), .be_byte_o(beb), .be_pix_o(bep),
        .cols_o(cols), .rows_o(rows), .base_o(base)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_tim [4];
    logic [31:0] m_upb, m_lpb, m_ctrl, m_rdata;
    logic [3:0]  m_raw, m_mask;
    int          m_cols, m_rows;
    logic        m_irq, m_err;
    byte unsigned id_tab [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_tim[i]) m_tim[i] = '0;
            m_upb = '0; m_lpb = '0; m_ctrl = '0; m_rdata = '0;
            m_raw = '0; m_mask = '0; m_cols = 0; m_rows = 0;
            m_irq = 1'b0; m_err = 1'b0;
        end else begin
            int   ix;
            bit   ok;
            logic [31:0] rv;
            logic [3:0]  clr;
            ix = int'(addr[11:2]);
            ok = (addr[1:0] == 2'b00);
            rv = '0;
            clr = '0;
            m_rdata = '0;
            m_err = 1'b0;
            if (sel && !wr) begin
                if (ix <= 3)       rv = m_tim[ix];
                else if (ix == 4 || ix == 11) rv = m_upb;
                else if (ix == 5 || ix == 12) rv = m_lpb;
                else if (ix == 6)  rv = variant ? m_ctrl : {28'd0, m_mask};
                else if (ix == 7)  rv = variant ? {28'd0, m_mask} : m_ctrl;
                else if (ix == 8)  rv = {28'd0, m_raw};
                else if (ix == 9)  rv = {28'd0, m_raw & m_mask};
                else if (ix >= 1016) rv = {24'd0, id_tab[ix-1016]};
                else ok = 1'b0;
                if (ok) m_rdata = rv; else m_err = 1'b1;
            end else if (sel && wr) begin
                if (!ok || ix > 10 || ix == 8 || ix == 9) begin
                    m_err = 1'b1;
                end else if (ix <= 3) begin
                    m_tim[ix] = wdata;
                    if (ix == 0) m_cols = ((int'(wdata) & 'hFC) + 4) * 4;
                    if (ix == 1) m_rows = (int'(wdata) & 'h3FF) + 1;
                end
                else if (ix == 4) m_upb = wdata;
                else if (ix == 5) m_lpb = wdata;
                else if (ix == 6) begin if (variant) m_ctrl = wdata; else m_mask = wdata[3:0]; end
                else if (ix == 7) begin if (variant) m_mask = wdata[3:0]; else m_ctrl = wdata; end
                else if (ix == 10) clr = wdata[3:0];
            end
            m_raw = (m_raw & ~clr) | iset;
            m_irq = |(m_raw & m_mask);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 rdata model",   rdata, m_rdata);
            chk("R12 err model",    {31'd0, err}, {31'd0, m_err});
            chk("R9 irq model",     {31'd0, irq}, {31'd0, m_irq});
            chk("R6 enable model",  {31'd0, en}, {31'd0, m_ctrl[0] & m_ctrl[11]});
            chk("R6 bpp model",     {29'd0, bpp}, {29'd0, m_ctrl[3:1]});
            chk("R6 flags model",   {29'd0, bgr, beb, bep}, {29'd0, m_ctrl[8], m_ctrl[9], m_ctrl[10]});
            chk("R4 cols model",    {21'd0, cols}, 32'(m_cols));
            chk("R5 rows model",    {21'd0, rows}, 32'(m_rows));
            chk("R13 base model",   base, m_upb);
        end
    end

    // ---------------- stimulus ----------------
    task automatic acc(input logic w, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = w; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        acc(1'b0, a, '0);
        chk(tag, rdata, exp);
    endtask

    task automatic pulse(input logic [3:0] v);
        @(negedge clk); iset = v;
        @(negedge clk); iset = '0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        chk("R1 reset outputs", {rdata[30:0] | base[30:0], err}, 32'd0);
        chk("R1 reset geometry", {10'd0, cols, rows} | {29'd0, en, irq, bgr}, 32'd0);

        // geometry
        acc(1'b1, 12'h000, 32'hFF);         chk("R4 cols max", 32'(cols), 32'd1024);
        acc(1'b1, 12'h000, 32'h2B);         chk("R4 cols mid", 32'(cols), 32'd176);
        acc(1'b1, 12'h000, 32'h0);          chk("R4 cols min", 32'(cols), 32'd16);
        acc(1'b1, 12'h004, 32'h1DF);        chk("R5 rows 480", 32'(rows), 32'd480);
        acc(1'b1, 12'h004, 32'hFFFFFC00);   chk("R5 rows min", 32'(rows), 32'd1);
        acc(1'b1, 12'h004, 32'h3FF);        chk("R5 rows max", 32'(rows), 32'd1024);

        // plain storage
        acc(1'b1, 12'h008, 32'hA5A50001);
        acc(1'b1, 12'h00C, 32'h12345678);
        acc(1'b1, 12'h010, 32'h80000000);
        acc(1'b1, 12'h014, 32'h00400000);
        rd(12'h000, 32'h0,        "R2 tim0 readback");
        rd(12'h004, 32'h3FF,      "R2 tim1 readback");
        rd(12'h008, 32'hA5A50001, "R2 tim2 readback");
        rd(12'h00C, 32'h12345678, "R2 tim3 readback");
        rd(12'h010, 32'h80000000, "R2 upper base readback");
        rd(12'h014, 32'h00400000, "R2 lower base readback");
        chk("R13 base follows upper", base, 32'h80000000);
        rd(12'h02C, 32'h80000000, "R10 upper current");
        rd(12'h030, 32'h00400000, "R10 lower current");

        // control, strap low
        acc(1'b1, 12'h01C, 32'h1);          chk("R6 enable without power", 32'(en), 32'd0);
        acc(1'b1, 12'h01C, 32'h801);        chk("R6 enable with power", 32'(en), 32'd1);
        acc(1'b1, 12'h01C, 32'h70B);
        chk("R6 bpp code", 32'(bpp), 32'd5);
        chk("R6 order flags", {29'd0, bgr, beb, bep}, 32'd7);
        chk("R6 power off", 32'(en), 32'd0);
        acc(1'b1, 12'h018, 32'h5);
        rd(12'h018, 32'h5,   "R3 strap low mask at 6");
        rd(12'h01C, 32'h70B, "R3 strap low control at 7");

        // control, strap high
        @(negedge clk) variant = 1'b1;
        rd(12'h018, 32'h70B, "R3 strap high control at 6");
        rd(12'h01C, 32'h5,   "R3 strap high mask at 7");
        acc(1'b1, 12'h018, 32'h801);        chk("R3 strap high write control", 32'(en), 32'd1);
        acc(1'b1, 12'h01C, 32'h3);
        rd(12'h01C, 32'h3,   "R3 strap high write mask");
        @(negedge clk) variant = 1'b0;
        rd(12'h018, 32'h3,   "R3 strap restored mask");
        rd(12'h01C, 32'h801, "R3 strap restored control");

        // interrupts (mask = 3)
        pulse(4'h4);                        chk("R9 unmasked bit no irq", 32'(irq), 32'd0);
        rd(12'h020, 32'h4, "R7 raw status");
        rd(12'h024, 32'h0, "R7 masked status");
        pulse(4'h1);                        chk("R9 masked bit raises irq", 32'(irq), 32'd1);
        rd(12'h024, 32'h1, "R7 masked status set");
        acc(1'b1, 12'h028, 32'h1);          chk("R8 clear drops irq", 32'(irq), 32'd0);
        rd(12'h020, 32'h4, "R8 other bit kept");
        @(negedge clk);
        iset = 4'h2; sel = 1'b1; wr = 1'b1; addr = 12'h028; wdata = 32'h2;
        @(negedge clk);
        iset = '0; sel = 1'b0; wr = 1'b0;
        chk("R7 set wins over clear", 32'(irq), 32'd1);
        rd(12'h020, 32'h6, "R7 raw after collision");
        acc(1'b1, 12'h018, 32'h0);          chk("R9 mask write drops irq", 32'(irq), 32'd0);
        acc(1'b1, 12'h028, 32'hF);
        rd(12'h020, 32'h0, "R8 full clear");

        // identification
        for (int k = 0; k < 8; k++)
            rd(12'hFE0 + 12'(4*k), 32'(id_tab[k]), "R11 ident byte");

        // unmapped accesses
        rd(12'h034, 32'h0, "R12 read hole");
        chk("R12 err pulse", 32'(err), 32'd1);
        @(negedge clk);
        chk("R12 err one cycle", 32'(err), 32'd0);
        rd(12'h200, 32'h0, "R12 read palette area");
        rd(12'h028, 32'h0, "R12 read clear word");
        chk("R12 err on write-only read", 32'(err), 32'd1);
        acc(1'b1, 12'h020, 32'hF);          chk("R12 err on raw write", 32'(err), 32'd1);
        rd(12'h020, 32'h0, "R12 raw unchanged");
        acc(1'b1, 12'hFE0, 32'hFF);
        rd(12'hFE0, 32'h10, "R12 ident unchanged");
        acc(1'b1, 12'h001, 32'hFF);         chk("R12 misaligned ignored", 32'(cols), 32'd16);
        acc(1'b1, 12'h02C, 32'h1);
        rd(12'h010, 32'h80000000, "R12 current not writable");

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule